// File: doc/BRIEF.md
# Conditional Backup and Write-Protect Controller

This block is the digital decision logic that sits between a set of supply comparators and the power switches of a battery-backed memory supply. It receives three comparator flags: the main supply is above the reset threshold, the supply is more than 50 mV above the battery, and the supply is more than 70 mV above the battery. It also receives a backup-request level from the processor. From these it drives the enables of the main and battery power switches and a battery-on indication. It also derives a low-line flag, gates the power-fail warning and blocks the memory chip-enable while the supply is invalid.

The backup request counts only at the moment the supply falls through the reset threshold. At that moment it is captured into a memory bit, and it is ignored at all other times. When the supply later collapses towards the battery voltage, this bit decides what happens. If it is high, the memory output is switched to the battery (backup mode). If it is low, both switches open and the output floats (battery-saving mode), which saves the battery when the memory contents need not survive. Switching back to the supply needs the higher 70 mV level, which gives 20 mV of hysteresis. A dead time between the two switch enables guarantees break-before-make.

The comparator flags and the request are asynchronous to the controller clock, so each passes through a `SYNC_STAGES`-deep synchroniser. The chip-enable path and the power-fail path stay combinational, so memory accesses see no added delay. The request input is expected to have a pull-up at the pad, so backup is the default. The captured bit also resets high, so the mode is defined from the first power-up.

Top module: `backup_wp_ctrl`

## Requirements
- R1: The backup-request level, after synchronisation, is stored in the memory bit only in the cycle where the synchronised reset-threshold flag goes from 1 to 0; changes of the request at any other time leave the stored bit and all outputs unchanged.
- R2: With the stored bit at 1, once the synchronised 50 mV flag is 0, the main switch enable drops at once and the battery switch enable rises after the dead time.
- R3: With the stored bit at 0, once the synchronised 50 mV flag is 0, both switch enables are 0 (battery-saving mode).
- R4: Once on the battery side, the controller returns to the supply only when the synchronised 70 mV flag is 1; while the 50 mV flag is 1 and the 70 mV flag is 0, the current side is held.
- R5: `batt_on` is 1 exactly when the battery switch enable is 1 and is 0 while the output is fed from the supply.
- R6: `ce_out_n` equals `ce_in_n` (active low, combinational) while the synchronised reset-threshold flag is 1 and the controller is on the supply side; otherwise it is forced to 1.
- R7: `low_line_n` is 0 when the synchronised reset-threshold flag is 0 or the controller is on the battery side, and 1 otherwise.
- R8: On the battery side `pf_warn_n` is forced to 0; on the supply side it equals `pf_cmp`.
- R9: The two switch enables are never 1 together, and on every hand-over exactly `DEAD_CYCLES` cycles pass with both at 0 before the incoming switch is enabled.
- R10: After reset the controller is on the battery side with the stored bit at 1: main enable 0, battery enable 1, `batt_on` 1, `low_line_n` 0, `pf_warn_n` 0, `ce_out_n` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok_a | input | 1 | Supply above reset threshold (asynchronous) |
| above_lo_a | input | 1 | Supply more than 50 mV above battery (asynchronous) |
| above_hi_a | input | 1 | Supply more than 70 mV above battery (asynchronous) |
| keep_req_a | input | 1 | Backup request, 1 = keep memory powered |
| pf_cmp | input | 1 | Power-fail comparator output, 1 = input healthy |
| ce_in_n | input | 1 | Memory chip-enable from the decoder, active low |
| main_sw_en | output | 1 | Enable of the supply-to-output switch |
| batt_sw_en | output | 1 | Enable of the battery-to-output switch |
| batt_on | output | 1 | Output is fed from the battery |
| low_line_n | output | 1 | Low when the supply is invalid |
| pf_warn_n | output | 1 | Gated power-fail warning, low = warning |
| ce_out_n | output | 1 | Write-protected chip-enable, active low |

## Verification
The bench builds the controller with `SYNC_STAGES = 2` and `DEAD_CYCLES = 3`. This keeps the synchroniser latency short enough that a flag can fall and recover within a few cycles. It also makes the dead-time gap long enough to be counted, so the break-before-make window can be seen at the ports. Directed phases cover power-up through the hysteresis band and power-down with the request at 0 and at 1. They also toggle the request outside the capture cycle and let the threshold and 50 mV flags fall in the same cycle. A long stretch of random flag patterns then reaches the case where the 70 mV flag drops back while a dead time is still running.

// File: rtl/backup_wp_ctrl.sv
module backup_wp_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok_a,
  input  logic above_lo_a,
  input  logic above_hi_a,
  input  logic keep_req_a,
  input  logic pf_cmp,
  input  logic ce_in_n,
  output logic main_sw_en,
  output logic batt_sw_en,
  output logic batt_on,
  output logic low_line_n,
  output logic pf_warn_n,
  output logic ce_out_n
);

  localparam int CW = $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYCLES);

  logic [SYNC_STAGES-1:0] ok_sh, lo_sh, hi_sh, req_sh;
  logic ok_s, lo_s, hi_s, req_s;
  logic ok_d;
  logic keep_mem;
  logic on_batt;
  logic side_nxt;
  logic [CW-1:0] dead_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_sh  <= '0;
      lo_sh  <= '0;
      hi_sh  <= '0;
      req_sh <= '1;
    end else begin
      ok_sh  <= SYNC_STAGES'({ok_sh, vcc_ok_a});
      lo_sh  <= SYNC_STAGES'({lo_sh, above_lo_a});
      hi_sh  <= SYNC_STAGES'({hi_sh, above_hi_a});
      req_sh <= SYNC_STAGES'({req_sh, keep_req_a});
    end
  end

  assign ok_s  = ok_sh[SYNC_STAGES-1];
  assign lo_s  = lo_sh[SYNC_STAGES-1];
  assign hi_s  = hi_sh[SYNC_STAGES-1];
  assign req_s = req_sh[SYNC_STAGES-1];

  // capture the request only on the falling threshold crossing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_d     <= 1'b0;
      keep_mem <= 1'b1;
    end else begin
      ok_d <= ok_s;
      if (ok_d && !ok_s) keep_mem <= req_s;
    end
  end

  // side selection with hysteresis between the two comparator levels
  assign side_nxt = on_batt ? !hi_s : !lo_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_batt  <= 1'b1;
      dead_cnt <= '0;
    end else begin
      on_batt <= side_nxt;
      if (side_nxt != on_batt)
        dead_cnt <= DEAD_LOAD;
      else if (dead_cnt != '0)
        dead_cnt <= dead_cnt - 1'b1;
    end
  end

  assign main_sw_en = !on_batt && (dead_cnt == '0);
  assign batt_sw_en = on_batt && keep_mem && (dead_cnt == '0);
  assign batt_on    = batt_sw_en;
  assign low_line_n = ok_s && !on_batt;
  assign pf_warn_n  = on_batt ? 1'b0 : pf_cmp;
  assign ce_out_n   = low_line_n ? ce_in_n : 1'b1;

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_sw_en && batt_sw_en));

  p_batt_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batt_sw_en) |-> !$past(main_sw_en));

  p_main_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_sw_en) |-> !$past(batt_sw_en));

  p_mem_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_d && !ok_s) |=> $stable(keep_mem));

  p_stay_batt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (on_batt && !hi_s) |=> !main_sw_en);

  p_ce_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !low_line_n |-> ce_out_n);

  p_pf_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    batt_on |-> !pf_warn_n);

  p_saving_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_mem |-> !batt_sw_en);

endmodule

// File: tb/backup_wp_ctrl_test.sv
module backup_wp_ctrl_test;
  localparam int S = 2;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok_a = 1'b0, above_lo_a = 1'b0, above_hi_a = 1'b0;
  logic keep_req_a = 1'b1, pf_cmp = 1'b1, ce_in_n = 1'b1;
  logic main_sw_en, batt_sw_en, batt_on, low_line_n, pf_warn_n, ce_out_n;

  int checks = 0;
  int errors = 0;
  string tag = "R10";

  backup_wp_ctrl #(.SYNC_STAGES(S), .DEAD_CYCLES(D)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_ok_a(vcc_ok_a), .above_lo_a(above_lo_a),
    .above_hi_a(above_hi_a), .keep_req_a(keep_req_a), .pf_cmp(pf_cmp),
    .ce_in_n(ce_in_n), .main_sw_en(main_sw_en), .batt_sw_en(batt_sw_en),
    .batt_on(batt_on), .low_line_n(low_line_n), .pf_warn_n(pf_warn_n),
    .ce_out_n(ce_out_n));

  always #2.5 clk = ~clk;

  // behavioural reference: delay lines plus a side/mode/timer model
  bit q_ok[$], q_lo[$], q_hi[$], q_req[$];
  bit m_batt, m_mem, m_prev;
  int m_wait;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_ok = {}; q_lo = {}; q_hi = {}; q_req = {};
      for (int i = 0; i < S; i++) begin
        q_ok.push_back(1'b0); q_lo.push_back(1'b0);
        q_hi.push_back(1'b0); q_req.push_back(1'b1);
      end
      m_batt = 1'b1; m_mem = 1'b1; m_prev = 1'b0; m_wait = 0;
    end else begin
      bit want_batt;
      if (m_prev && !q_ok[0]) m_mem = q_req[0];
      m_prev = q_ok[0];
      if (m_batt) want_batt = !q_hi[0];
      else        want_batt = !q_lo[0];
      if (want_batt != m_batt) m_wait = D;
      else if (m_wait > 0) m_wait--;
      m_batt = want_batt;
      q_ok.push_back(vcc_ok_a);    void'(q_ok.pop_front());
      q_lo.push_back(above_lo_a);  void'(q_lo.pop_front());
      q_hi.push_back(above_hi_a);  void'(q_hi.pop_front());
      q_req.push_back(keep_req_a); void'(q_req.pop_front());
    end
  end

  task automatic chk(input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic step();
    bit e_main, e_batt, e_ll;
    @(negedge clk);
    e_main = !m_batt && m_wait == 0;
    e_batt = m_batt && m_mem && m_wait == 0;
    e_ll   = q_ok[0] && !m_batt;
    chk("main_sw_en", main_sw_en, e_main);
    chk("batt_sw_en", batt_sw_en, e_batt);
    chk("batt_on R5", batt_on, e_batt);
    chk("low_line_n R7", low_line_n, e_ll);
    chk("pf_warn_n R8", pf_warn_n, m_batt ? 1'b0 : pf_cmp);
    chk("ce_out_n R6", ce_out_n, e_ll ? ce_in_n : 1'b1);
    chk("no overlap R9", main_sw_en && batt_sw_en, 1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int gap;
    bit seen_drop;
    repeat (3) @(negedge clk);
    tag = "R10";
    chk("reset main", main_sw_en, 1'b0);
    chk("reset batt", batt_sw_en, 1'b1);
    chk("reset low_line", low_line_n, 1'b0);
    chk("reset pf", pf_warn_n, 1'b0);
    chk("reset ce", ce_out_n, 1'b1);
    rst_n = 1'b1;
    run(3);

    tag = "R4";                       // power-up inside the hysteresis band
    above_lo_a = 1'b1; run(8);
    chk("R4 held on battery", main_sw_en, 1'b0);
    above_hi_a = 1'b1; run(S + D + 2);
    chk("R4 main reconnected", main_sw_en, 1'b1);

    tag = "R6";
    vcc_ok_a = 1'b1; run(S + 1);
    for (int i = 0; i < 6; i++) begin ce_in_n = i[0]; pf_cmp = i[1]; step(); end
    tag = "R1";                       // request toggles away from the capture edge
    for (int i = 0; i < 6; i++) begin keep_req_a = i[0]; step(); end

    tag = "R3";                       // power-down with request low
    keep_req_a = 1'b0; run(S + 1);
    vcc_ok_a = 1'b0; run(S + 2);
    keep_req_a = 1'b1; run(S + 2);    // R1: ignored after capture
    above_hi_a = 1'b0; run(3);
    above_lo_a = 1'b0; run(S + D + 3);
    chk("R3 saving both off", main_sw_en | batt_sw_en, 1'b0);
    ce_in_n = 1'b0; pf_cmp = 1'b1; step();
    chk("R6 forced high", ce_out_n, 1'b1);

    tag = "R4";
    above_lo_a = 1'b1; run(S + 4);
    chk("R4 band holds", main_sw_en, 1'b0);
    above_hi_a = 1'b1; run(S + D + 2);
    vcc_ok_a = 1'b1; run(S + 2);

    tag = "R2";                       // power-down with request high
    keep_req_a = 1'b1; run(S + 1);
    vcc_ok_a = 1'b0; run(S + 2);
    keep_req_a = 1'b0; run(S + 2);
    above_hi_a = 1'b0; above_lo_a = 1'b0;
    gap = 0; seen_drop = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!main_sw_en && !batt_sw_en) begin gap++; seen_drop = 1; end
      if (batt_sw_en) break;
    end
    tag = "R9";
    chk("R9 dead time exact", gap == D, 1'b1);
    chk("R2 battery engaged", batt_sw_en && seen_drop, 1'b1);

    tag = "R4";
    above_lo_a = 1'b1; above_hi_a = 1'b1; run(S + D + 3);
    vcc_ok_a = 1'b1; run(S + 2);
    tag = "R1";                       // simultaneous fall of threshold and 50 mV flag
    keep_req_a = 1'b0; run(S + 1);
    vcc_ok_a = 1'b0; above_lo_a = 1'b0; above_hi_a = 1'b0; run(S + D + 3);
    chk("R1 captured low", batt_sw_en, 1'b0);

    tag = "R9";                       // random flag activity
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] r = 8'($urandom);
      if (r[0]) vcc_ok_a = r[1];
      if (r[2]) above_lo_a = r[3];
      if (r[4]) above_hi_a = r[5];
      keep_req_a = r[6]; ce_in_n = r[7]; pf_cmp = r[1] ^ r[7];
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule